// File: doc/BRIEF.md
# Static LCD Segment Driver

This block drives a direct-drive (static) liquid crystal display from a latched reading. The reading is a set of BCD digits (three by default), a single leading-one bit for the thousands position, a sign bit and an overrange flag. The block decodes each digit to seven segments. It adds one line for the leading "1" and one line for the minus sign. It also generates a square-wave backplane.

An LCD must never see a DC voltage. Every output toggles at the backplane rate for that reason. A dark (on) segment is driven in antiphase to the backplane. A clear (off) segment is driven in phase with it.

The reading is captured on a single-cycle load strobe. The captured data moves to the pins only on a backplane edge, so no segment changes inside a half period. The backplane half period is a parameter. Its default of 400 oscillator cycles makes the backplane the oscillator divided by 800. That is twenty backplane periods per conversion of 16,000 oscillator cycles.

Top module: `lcd_static_drv`

## Requirements
- R1: During reset and until the first backplane edge after reset, `bp_o`, every bit of `seg_o`, `half_o` and `minus_o` are 0.
- R2: `bp_o` changes exactly once every HALF_PERIOD clock cycles, giving a 50% duty square wave (default HALF_PERIOD = 400, oscillator/800).
- R3: `seg_o`, `half_o` and `minus_o` change only on the clock edge at which `bp_o` changes.
- R4: Every segment-type output equals `bp_o` when its segment is off and the inverse of `bp_o` when it is on.
- R5: Digit k (k = 0 for units, 1 tens, 2 hundreds) comes from `digits_i[4k+3:4k]` and drives `seg_o[7k+6:7k]` with bit order a (bit 0) through g (bit 6). With default parameters, 0..9 light a-f; b,c; a,b,d,e,g; a,b,c,d,g; b,c,f,g; a,c,d,f,g; a,c,d,e,f,g; a,b,c; all seven; a,b,c,d,f,g.
- R6: BCD codes 10 to 15 light no segment of their digit.
- R7: `half_o` is on when the latched thousands bit is 1 or the latched overrange flag is 1.
- R8: `minus_o` is on exactly when the latched sign bit is 1.
- R9: When the latched overrange flag is 1, every digit segment is off, whatever the digit inputs are.
- R10: The inputs are captured only in a cycle with `load_i` high. The captured reading appears at the pins by the second backplane edge after the load. Input changes without a load have no effect.
- R11: With SIX_NINE_TAILS = 0, a 6 lights c,d,e,f,g without a, and a 9 lights a,b,c,f,g without d. All other codes are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture strobe for the reading inputs |
| digits_i | input | 4*NUM_DIGITS | BCD digits, units in the lowest nibble |
| thou_i | input | 1 | Leading "1" for the thousands position |
| neg_i | input | 1 | Reading is negative |
| ovr_i | input | 1 | Reading is over range |
| seg_o | output | 7*NUM_DIGITS | Segment drives, seven per digit, bit 0 = segment a |
| half_o | output | 1 | Leading-one drive (segments b and c of the thousands position) |
| minus_o | output | 1 | Minus-sign drive |
| bp_o | output | 1 | Backplane square wave |

## Verification
The bench builds the main instance with HALF_PERIOD = 4 so that each backplane half period lasts four cycles. That makes many backplane edges, and the wait of two edges after each load, cheap to reach. A second instance runs alongside it with HALF_PERIOD = 3 and SIX_NINE_TAILS = 0. It is fed the same reading, so the tailless digit variant and an odd divider length are both covered. The table covers every BCD code, the invalid codes, sign, leading one and overrange blanking. Directed steps cover the reset state, the period length, stability inside a half period and inputs that change without a load.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

   localparam int SEG_PER_DIGIT = 7;
   localparam int BCD_W         = 4;

   typedef logic [SEG_PER_DIGIT-1:0] seg7_t;

   // bit 0 = a ... bit 6 = g ; digits 6 and 9 carry their tails
   function automatic seg7_t bcd_seg_tailed(input logic [BCD_W-1:0] v);
      seg7_t s;
      case (v)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

   // same table, 6 without segment a and 9 without segment d
   function automatic seg7_t bcd_seg_plain(input logic [BCD_W-1:0] v);
      seg7_t s;
      case (v)
         4'd6:    s = 7'h7C;
         4'd9:    s = 7'h67;
         default: s = bcd_seg_tailed(v);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcd_bp_timer.sv
module lcd_bp_timer #(
   parameter int HALF_PERIOD = 400
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o,
   output logic bp_o
);
   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bp_o  <= 1'b0;
      end else begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
         bp_o  <= bp_o ^ tick_o;
      end
   end
endmodule

// File: rtl/lcd_reading_latch.sv
module lcd_reading_latch #(
   parameter int NUM_DIGITS = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [4*NUM_DIGITS-1:0] digits_i,
   input  logic                    thou_i,
   input  logic                    neg_i,
   input  logic                    ovr_i,
   output logic [4*NUM_DIGITS-1:0] digits_q,
   output logic                    thou_q,
   output logic                    neg_q,
   output logic                    ovr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digits_q <= '0;
         thou_q   <= 1'b0;
         neg_q    <= 1'b0;
         ovr_q    <= 1'b0;
      end else if (load_i) begin
         digits_q <= digits_i;
         thou_q   <= thou_i;
         neg_q    <= neg_i;
         ovr_q    <= ovr_i;
      end
   end
endmodule

// File: rtl/lcd_seg_decoder.sv
module lcd_seg_decoder #(
   parameter int NUM_DIGITS     = 3,
   parameter bit SIX_NINE_TAILS = 1'b1
) (
   input  logic                    [4*NUM_DIGITS-1:0] digits_i,
   input  logic                                       thou_i,
   input  logic                                       neg_i,
   input  logic                                       ovr_i,
   output logic [lcd_pkg::SEG_PER_DIGIT*NUM_DIGITS-1:0] seg_on_o,
   output logic                                       half_on_o,
   output logic                                       minus_on_o
);
   import lcd_pkg::*;

   for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
      logic [BCD_W-1:0] nib;
      seg7_t            raw;
      assign nib = digits_i[BCD_W*k +: BCD_W];
      if (SIX_NINE_TAILS) begin : g_tailed
         assign raw = bcd_seg_tailed(nib);
      end else begin : g_plain
         assign raw = bcd_seg_plain(nib);
      end
      assign seg_on_o[SEG_PER_DIGIT*k +: SEG_PER_DIGIT] = ovr_i ? '0 : raw;
   end

   assign half_on_o  = thou_i | ovr_i;
   assign minus_on_o = neg_i;
endmodule

// File: rtl/lcd_phase_out.sv
module lcd_phase_out #(
   parameter int W = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         bp_i,
   input  logic [W-1:0] on_i,
   output logic [W-1:0] drv_o
);
   // the new backplane level is ~bp_i; on bits invert it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         drv_o <= '0;
      else if (tick_i)
         drv_o <= on_i ^ {W{~bp_i}};
   end
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv #(
   parameter int NUM_DIGITS     = 3,
   parameter int HALF_PERIOD    = 400,
   parameter bit SIX_NINE_TAILS = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [4*NUM_DIGITS-1:0] digits_i,
   input  logic                    thou_i,
   input  logic                    neg_i,
   input  logic                    ovr_i,
   output logic [7*NUM_DIGITS-1:0] seg_o,
   output logic                    half_o,
   output logic                    minus_o,
   output logic                    bp_o
);
   localparam int SEG_W = lcd_pkg::SEG_PER_DIGIT * NUM_DIGITS;
   localparam int DRV_W = SEG_W + 2;

   if (NUM_DIGITS < 1 || NUM_DIGITS > 8) begin : g_bad_digits
      $error("NUM_DIGITS must be 1..8");
   end
   if (HALF_PERIOD < 2) begin : g_bad_period
      $error("HALF_PERIOD must be at least 2");
   end

   logic [4*NUM_DIGITS-1:0] dig_q;
   logic                    thou_q, neg_q, ovr_q;
   logic [SEG_W-1:0]        seg_on;
   logic                    half_on, minus_on;
   logic                    tick;
   logic [DRV_W-1:0]        drv;

   lcd_bp_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick),
      .bp_o   (bp_o)
   );

   lcd_reading_latch #(.NUM_DIGITS(NUM_DIGITS)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .digits_i (digits_i),
      .thou_i   (thou_i),
      .neg_i    (neg_i),
      .ovr_i    (ovr_i),
      .digits_q (dig_q),
      .thou_q   (thou_q),
      .neg_q    (neg_q),
      .ovr_q    (ovr_q)
   );

   lcd_seg_decoder #(
      .NUM_DIGITS     (NUM_DIGITS),
      .SIX_NINE_TAILS (SIX_NINE_TAILS)
   ) u_dec (
      .digits_i   (dig_q),
      .thou_i     (thou_q),
      .neg_i      (neg_q),
      .ovr_i      (ovr_q),
      .seg_on_o   (seg_on),
      .half_on_o  (half_on),
      .minus_on_o (minus_on)
   );

   lcd_phase_out #(.W(DRV_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .bp_i   (bp_o),
      .on_i   ({minus_on, half_on, seg_on}),
      .drv_o  (drv)
   );

   assign seg_o   = drv[SEG_W-1:0];
   assign half_o  = drv[SEG_W];
   assign minus_o = drv[SEG_W+1];
endmodule

// File: rtl/lcd_static_drv_chk.sv
module lcd_static_drv_chk #(
   parameter int NUM_DIGITS  = 3,
   parameter int HALF_PERIOD = 400
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    load_i,
   input logic                    thou_i,
   input logic                    neg_i,
   input logic                    ovr_i,
   input logic [7*NUM_DIGITS-1:0] seg_o,
   input logic                    half_o,
   input logic                    minus_o,
   input logic                    bp_o
);
   localparam int RW = $clog2(HALF_PERIOD + 2) + 1;
   localparam logic [RW-1:0] HP = RW'(HALF_PERIOD);

   logic [RW-1:0] run_q;
   logic          bp_prev;
   logic          lat_thou, lat_neg, lat_ovr;
   logic          lat_thou_d, lat_neg_d, lat_ovr_d;
   logic          shw_thou, shw_neg, shw_ovr;
   logic          bp_edge;

   assign bp_edge = (bp_o != bp_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= '0;
         bp_prev  <= 1'b0;
         lat_thou <= 1'b0; lat_neg <= 1'b0; lat_ovr <= 1'b0;
         lat_thou_d <= 1'b0; lat_neg_d <= 1'b0; lat_ovr_d <= 1'b0;
         shw_thou <= 1'b0; shw_neg <= 1'b0; shw_ovr <= 1'b0;
      end else begin
         bp_prev <= bp_o;
         if (bp_edge)
            run_q <= RW'(1);
         else if (run_q != '1)
            run_q <= run_q + 1'b1;
         if (load_i) begin
            lat_thou <= thou_i; lat_neg <= neg_i; lat_ovr <= ovr_i;
         end
         lat_thou_d <= lat_thou; lat_neg_d <= lat_neg; lat_ovr_d <= lat_ovr;
         if (bp_edge) begin
            shw_thou <= lat_thou_d; shw_neg <= lat_neg_d; shw_ovr <= lat_ovr_d;
         end
      end
   end

   assert_bp_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bp_edge |-> (run_q == HP));

   assert_bp_no_stretch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_edge |-> (run_q < HP));

   assert_drive_only_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(bp_o) |-> $stable({seg_o, half_o, minus_o}));

   assert_ovr_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bp_edge && shw_ovr) |-> (seg_o == {(7*NUM_DIGITS){bp_o}}));

   assert_half_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_edge |-> (half_o == (bp_o ^ (shw_thou | shw_ovr))));

   assert_minus_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_edge |-> (minus_o == (bp_o ^ shw_neg)));
endmodule

bind lcd_static_drv lcd_static_drv_chk #(
   .NUM_DIGITS  (NUM_DIGITS),
   .HALF_PERIOD (HALF_PERIOD)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_i  (load_i),
   .thou_i  (thou_i),
   .neg_i   (neg_i),
   .ovr_i   (ovr_i),
   .seg_o   (seg_o),
   .half_o  (half_o),
   .minus_o (minus_o),
   .bp_o    (bp_o)
);

// File: tb/tb_lcd_static_drv.sv
module tb_lcd_static_drv;
   localparam int HP  = 4;
   localparam int HP2 = 3;
   localparam int NV  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [11:0] digits_i = '0;
   logic        thou_i = 1'b0, neg_i = 1'b0, ovr_i = 1'b0;
   logic [20:0] seg_o, seg2_o;
   logic        half_o, minus_o, bp_o, half2_o, minus2_o, bp2_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   lcd_static_drv #(.HALF_PERIOD(HP)) dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .digits_i(digits_i),
      .thou_i(thou_i), .neg_i(neg_i), .ovr_i(ovr_i),
      .seg_o(seg_o), .half_o(half_o), .minus_o(minus_o), .bp_o(bp_o));

   lcd_static_drv #(.HALF_PERIOD(HP2), .SIX_NINE_TAILS(1'b0)) dut_plain (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .digits_i(digits_i),
      .thou_i(thou_i), .neg_i(neg_i), .ovr_i(ovr_i),
      .seg_o(seg2_o), .half_o(half2_o), .minus_o(minus2_o), .bp_o(bp2_o));

   // {ovr, neg, thou, digits[11:0], seg[20:0] (hund,tens,units), half, minus}
   localparam logic [37:0] VEC [NV] = '{
      {3'b000, 12'h000, 7'h3F, 7'h3F, 7'h3F, 2'b00},  // R5 zeros
      {3'b000, 12'h123, 7'h06, 7'h5B, 7'h4F, 2'b00},  // R5
      {3'b010, 12'h456, 7'h66, 7'h6D, 7'h7D, 2'b01},  // R5 R8
      {3'b001, 12'h789, 7'h07, 7'h7F, 7'h6F, 2'b10},  // R5 R7
      {3'b000, 12'hABF, 7'h00, 7'h00, 7'h00, 2'b00},  // R6
      {3'b000, 12'h9C0, 7'h6F, 7'h00, 7'h3F, 2'b00},  // R6 mixed
      {3'b110, 12'h888, 7'h00, 7'h00, 7'h00, 2'b11},  // R9 R7 R8
      {3'b011, 12'h0E5, 7'h3F, 7'h00, 7'h6D, 2'b11}   // R6 R7 R8
   };

   task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_reading(input logic [11:0] d, input logic th, input logic ng,
                               input logic ov);
      @(negedge clk);
      digits_i = d; thou_i = th; neg_i = ng; ovr_i = ov; load_i = 1'b1;
      @(negedge clk);
      load_i = 1'b0;
      repeat (2*HP + 2) @(negedge clk);
   endtask

   task automatic wait_bp_edge(output int n);
      logic b;
      b = bp_o;
      n = 0;
      while (bp_o == b && n < 100) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int n;
      logic [22:0] snap;
      logic        bsnap;
      // R1: reset state and the first cycles after release
      repeat (3) @(negedge clk);
      chk("R1 in reset", {minus_o, half_o, seg_o}, '0);
      chk("R1 bp in reset", {22'd0, bp_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {bp_o, minus_o, half_o, seg_o[19:0]}, '0);

      // R2: half period length, measured twice
      wait_bp_edge(n);
      wait_bp_edge(n);
      chk("R2 half period", 23'(n), 23'(HP));
      wait_bp_edge(n);
      chk("R2 half period", 23'(n), 23'(HP));

      // R4 R5 R6 R7 R8 R9 R10: table walk
      for (int i = 0; i < NV; i++) begin
         load_reading(VEC[i][34:23], VEC[i][35], VEC[i][36], VEC[i][37]);
         chk($sformatf("R4 R5 vector %0d", i), {minus_o, half_o, seg_o},
             {VEC[i][0], VEC[i][1], VEC[i][22:2]} ^ {23{bp_o}});
      end

      // R10: inputs change without load, display keeps the last reading
      @(negedge clk);
      digits_i = 12'h111; thou_i = 1'b0; neg_i = 1'b0; ovr_i = 1'b0;
      repeat (3*HP) @(negedge clk);
      chk("R10 no load ignored", {minus_o, half_o, seg_o},
          {2'b11, 7'h3F, 7'h00, 7'h6D} ^ {23{bp_o}});

      // R3: outputs hold inside a half period
      wait_bp_edge(n);
      snap = {minus_o, half_o, seg_o};
      bsnap = bp_o;
      @(negedge clk); @(negedge clk);
      chk("R3 bp held", {22'd0, bp_o}, {22'd0, bsnap});
      chk("R3 outputs held", {minus_o, half_o, seg_o}, snap);

      // R11: tailless variant next to the default one
      load_reading(12'h069, 1'b0, 1'b0, 1'b0);
      chk("R5 tailed 6 and 9", {minus_o, half_o, seg_o},
          {2'b00, 7'h3F, 7'h7D, 7'h6F} ^ {23{bp_o}});
      chk("R11 plain 6 and 9", {minus2_o, half2_o, seg2_o},
          {2'b00, 7'h3F, 7'h7C, 7'h67} ^ {23{bp2_o}});

      // R4: same reading seen on the opposite backplane level
      wait_bp_edge(n);
      chk("R4 opposite phase", {minus_o, half_o, seg_o},
          {2'b00, 7'h3F, 7'h7D, 7'h6F} ^ {23{bp_o}});

      // R9: overrange blanks digits in the tailless instance too
      load_reading(12'h999, 1'b0, 1'b0, 1'b1);
      chk("R9 plain blank", {minus2_o, half2_o, seg2_o}, {2'b01, 21'd0} ^ {23{bp2_o}});

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule